// File: doc/BRIEF.md
# Three-Stage Prefetch Pipeline Sequencer

This block sequences the front end of a small processor that runs either 32-bit instruction words or 16-bit halfwords. On every clock it fetches at the program counter, slides the fetched word into a decode slot, and offers the word that was in the decode slot to the execute stage. The actual decoding and execution of instructions is out of scope. Only the overlap and the address arithmetic are modelled here.

After reset and after every taken flush, two refill steps run before any word is issued. The words fetched along the old path are therefore never issued and can never raise an illegal-instruction trap. A flush is requested by the instruction in execute. It carries a target address and the instruction mode that applies from the target onward. The execute stage sees the issued word, its address, a valid strobe and a gated trap. A registered retire pulse follows each issue by one cycle.

Top module: `prefetch_seq`

## Requirements
- R1: While and directly after reset, `fetch_addr_o` and `next_addr_o` equal RESET_PC. `exec_valid_o`, `retire_o` and `trap_o` are 0, and `half_mode_o` is 0 (32-bit mode).
- R2: After reset or a taken flush, exactly two steps have `exec_valid_o` = 0. In each of them the fetch address advances by one instruction size. The third step issues.
- R3: The instruction size is 4 bytes when `half_mode_o` = 0 and 2 bytes when it is 1. In 16-bit mode, bits 31:16 of a fetched word are cleared on entry to the slots, so `exec_word_o[31:16]` = 0.
- R4: The word issued in a step is the word presented on `fetch_data_i` two steps earlier, which is the word fetched at `exec_addr_o`.
- R5: While issuing, `exec_addr_o` = `fetch_addr_o` − 2 × size.
- R6: A flush requested while issuing loads the fetch address with the target with bit 0 forced to 0, without an increment, and returns the sequencer to the first refill step.
- R7: A flush request while `exec_valid_o` = 0 has no effect: the address advances normally and the refill continues.
- R8: `next_addr_o` = PC in the first refill step, PC − size in the second refill step, and PC − 2 × size while issuing, where PC is `fetch_addr_o`.
- R9: `trap_o` = `illegal_i` while issuing and 0 otherwise. An illegal flag during refill has no effect.
- R10: A taken flush loads the instruction mode from `flush_half_i`, and the first refill step already advances by the new size. The mode does not change at any other time.
- R11: `retire_o` is 1 in exactly the step after each step with `exec_valid_o` = 1.
- R12: While issuing with no flush, the sequencer stays in execute and the fetch address advances by one size per step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every rising edge is one pipeline step |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_data_i | input | IW | Instruction data read at `fetch_addr_o` |
| flush_req_i | input | 1 | Redirect request from the issued instruction |
| flush_addr_i | input | AW | Redirect target address |
| flush_half_i | input | 1 | Mode after redirect (1 = 16-bit) |
| illegal_i | input | 1 | Decoder reports the issued word as illegal |
| fetch_addr_o | output | AW | Program counter / fetch address |
| half_mode_o | output | 1 | Current mode (1 = 16-bit) |
| exec_valid_o | output | 1 | A word is issued this step |
| exec_word_o | output | IW | Issued word |
| exec_addr_o | output | AW | Address of the issued word |
| next_addr_o | output | AW | Address of the next instruction to run |
| trap_o | output | 1 | Illegal word issued |
| retire_o | output | 1 | One-cycle pulse after each issue |

## Verification
The fetch address, mode, slot contents and sequencer state are registered. A stimulus applied in one step therefore shows up on the address, word and valid outputs in the next step. An issued word reaches `exec_word_o` two steps after it was fetched, and `retire_o` rises one step after an issue. `trap_o`, `exec_addr_o` and `next_addr_o` are combinational from the current state. The bench drives inputs just after a falling edge and compares all outputs one time unit later, before the next rising edge. It advances its own arithmetic model of PC, state and mode at that rising edge, so each expected value is tied to the step in which it is due.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        ST_REFILL1 = 2'd0,
        ST_REFILL2 = 2'd1,
        ST_EXECUTE = 2'd2
    } seq_state_e;

    typedef struct packed {
        seq_state_e state;
        logic       half;
        logic       retire;
    } ctrl_s;
endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
    import pfq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       flush_req_i,
    input  logic       flush_half_i,
    output seq_state_e state_o,
    output logic       half_o,
    output logic       issue_o,
    output logic       take_flush_o,
    output logic       retire_o
);
    ctrl_s ctrl_d, ctrl_q;
    logic  issue, take_flush;

    always_comb begin
        ctrl_d     = ctrl_q;
        issue      = (ctrl_q.state == ST_EXECUTE);
        take_flush = issue && flush_req_i;
        ctrl_d.retire = issue;
        case (ctrl_q.state)
            ST_REFILL1: ctrl_d.state = ST_REFILL2;
            ST_REFILL2: ctrl_d.state = ST_EXECUTE;
            ST_EXECUTE: begin
                if (take_flush) begin
                    ctrl_d.state = ST_REFILL1;
                    ctrl_d.half  = flush_half_i;
                end
            end
            default:    ctrl_d.state = ST_REFILL1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.state  <= ST_REFILL1;
            ctrl_q.half   <= 1'b0;
            ctrl_q.retire <= 1'b0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign state_o      = ctrl_q.state;
    assign half_o       = ctrl_q.half;
    assign issue_o      = issue;
    assign take_flush_o = take_flush;
    assign retire_o     = ctrl_q.retire;
endmodule

// File: rtl/pfq_pc.sv
module pfq_pc
    import pfq_pkg::*;
#(
    parameter int          AW       = 32,
    parameter int          IW       = 32,
    parameter int          HW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_i,
    input  seq_state_e    state_i,
    input  logic          take_flush_i,
    input  logic [AW-1:0] flush_addr_i,
    output logic [AW-1:0] pc_o,
    output logic [AW-1:0] exec_addr_o,
    output logic [AW-1:0] next_addr_o
);
    localparam logic [AW-1:0] WORD_BYTES = AW'(IW / 8);
    localparam logic [AW-1:0] HALF_BYTES = AW'(HW / 8);
    localparam logic [AW-1:0] ALIGN_MASK = ~AW'(1);

    logic [AW-1:0] pc_d, pc_q;
    logic [AW-1:0] size;

    always_comb begin
        size = half_i ? HALF_BYTES : WORD_BYTES;
        if (take_flush_i) pc_d = flush_addr_i & ALIGN_MASK;
        else              pc_d = pc_q + size;
        exec_addr_o = pc_q - (size << 1);
        case (state_i)
            ST_REFILL1: next_addr_o = pc_q;
            ST_REFILL2: next_addr_o = pc_q - size;
            default:    next_addr_o = pc_q - (size << 1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pc_q <= RESET_PC;
        else        pc_q <= pc_d;
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/pfq_slots.sv
module pfq_slots #(
    parameter int IW = 32,
    parameter int HW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          half_i,
    input  logic [IW-1:0] fetch_data_i,
    output logic [IW-1:0] decode_o
);
    typedef struct packed {
        logic [IW-1:0] fetched;
        logic [IW-1:0] decoded;
    } slots_s;

    slots_s        slots_d, slots_q;
    logic [IW-1:0] narrow;

    generate
        if (HW < IW) begin : g_narrow
            assign narrow = {{(IW-HW){1'b0}}, fetch_data_i[HW-1:0]};
        end else begin : g_same
            assign narrow = fetch_data_i;
        end
    endgenerate

    always_comb begin
        slots_d.fetched = half_i ? narrow : fetch_data_i;
        slots_d.decoded = slots_q.fetched;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) slots_q <= '0;
        else        slots_q <= slots_d;
    end

    assign decode_o = slots_q.decoded;
endmodule

// File: rtl/prefetch_seq.sv
module prefetch_seq
    import pfq_pkg::*;
#(
    parameter int            AW       = 32,
    parameter int            IW       = 32,
    parameter int            HW       = 16,
    parameter logic [AW-1:0] RESET_PC = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [IW-1:0] fetch_data_i,
    input  logic          flush_req_i,
    input  logic [AW-1:0] flush_addr_i,
    input  logic          flush_half_i,
    input  logic          illegal_i,
    output logic [AW-1:0] fetch_addr_o,
    output logic          half_mode_o,
    output logic          exec_valid_o,
    output logic [IW-1:0] exec_word_o,
    output logic [AW-1:0] exec_addr_o,
    output logic [AW-1:0] next_addr_o,
    output logic          trap_o,
    output logic          retire_o
);
    seq_state_e state;
    logic       half, issue, take_flush;

    pfq_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_req_i  (flush_req_i),
        .flush_half_i (flush_half_i),
        .state_o      (state),
        .half_o       (half),
        .issue_o      (issue),
        .take_flush_o (take_flush),
        .retire_o     (retire_o)
    );

    pfq_pc #(.AW(AW), .IW(IW), .HW(HW), .RESET_PC(RESET_PC)) u_pc (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_i       (half),
        .state_i      (state),
        .take_flush_i (take_flush),
        .flush_addr_i (flush_addr_i),
        .pc_o         (fetch_addr_o),
        .exec_addr_o  (exec_addr_o),
        .next_addr_o  (next_addr_o)
    );

    pfq_slots #(.IW(IW), .HW(HW)) u_slots (
        .clk          (clk),
        .rst_n        (rst_n),
        .half_i       (half),
        .fetch_data_i (fetch_data_i),
        .decode_o     (exec_word_o)
    );

    assign half_mode_o  = half;
    assign exec_valid_o = issue;
    assign trap_o       = issue && illegal_i;
endmodule

// File: rtl/pfq_chk.sv
module pfq_chk #(
    parameter int AW = 32,
    parameter int IW = 32,
    parameter int HW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          flush_req_i,
    input logic [AW-1:0] flush_addr_i,
    input logic          flush_half_i,
    input logic          illegal_i,
    input logic [AW-1:0] fetch_addr_o,
    input logic          half_mode_o,
    input logic          exec_valid_o,
    input logic [AW-1:0] exec_addr_o,
    input logic [AW-1:0] next_addr_o,
    input logic          trap_o,
    input logic          retire_o
);
    localparam logic [AW-1:0] WB = AW'(IW / 8);
    localparam logic [AW-1:0] HB = AW'(HW / 8);

    logic taken;
    assign taken = exec_valid_o && flush_req_i;

    // R2
    refill_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> !exec_valid_o);
    // R2
    refill_second_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> ##2 !exec_valid_o);
    // R12
    stay_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid_o && !flush_req_i) |=> exec_valid_o);
    // R12
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> fetch_addr_o == $past(fetch_addr_o) + (half_mode_o ? HB : WB));
    // R6
    flush_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> fetch_addr_o == {$past(flush_addr_i[AW-1:1]), 1'b0});
    // R10
    mode_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        taken |=> half_mode_o == $past(flush_half_i));
    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |=> $stable(half_mode_o));
    // R9
    trap_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> (exec_valid_o && illegal_i));
    // R11
    retire_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid_o |=> retire_o);
    // R11
    retire_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid_o |=> !retire_o);
    // R8
    next_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid_o |-> next_addr_o == exec_addr_o);
endmodule

bind prefetch_seq pfq_chk #(.AW(AW), .IW(IW), .HW(HW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .flush_req_i  (flush_req_i),
    .flush_addr_i (flush_addr_i),
    .flush_half_i (flush_half_i),
    .illegal_i    (illegal_i),
    .fetch_addr_o (fetch_addr_o),
    .half_mode_o  (half_mode_o),
    .exec_valid_o (exec_valid_o),
    .exec_addr_o  (exec_addr_o),
    .next_addr_o  (next_addr_o),
    .trap_o       (trap_o),
    .retire_o     (retire_o)
);

// File: tb/prefetch_seq_tb.sv
`timescale 1ns/1ps
module prefetch_seq_tb;
    localparam logic [31:0] RST_PC = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] fetch_data;
    logic        flush_req, flush_half, illegal;
    logic [31:0] flush_addr;
    logic [31:0] fetch_addr, exec_word, exec_addr, next_addr;
    logic        half_mode, exec_valid, trap, retire;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    function automatic logic [31:0] memf(input logic [31:0] a);
        return (a * 32'h9E37_79B1) ^ 32'h5A5A_C3C3;
    endfunction

    assign fetch_data = memf(fetch_addr);

    prefetch_seq #(.AW(32), .IW(32), .HW(16), .RESET_PC(RST_PC)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .fetch_data_i (fetch_data),
        .flush_req_i  (flush_req),
        .flush_addr_i (flush_addr),
        .flush_half_i (flush_half),
        .illegal_i    (illegal),
        .fetch_addr_o (fetch_addr),
        .half_mode_o  (half_mode),
        .exec_valid_o (exec_valid),
        .exec_word_o  (exec_word),
        .exec_addr_o  (exec_addr),
        .next_addr_o  (next_addr),
        .trap_o       (trap),
        .retire_o     (retire)
    );

    // reference model
    logic [31:0] m_pc;
    int          m_state;
    logic        m_half, m_ret;
    int          m_last;   // 0 normal, 1 flush taken, 2 flush ignored

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_step(input logic fl, input logic [31:0] tgt,
                           input logic fh, input logic ill);
        logic        valid;
        logic [31:0] sz, ea, w;
        string       ftag;
        flush_req  = fl;
        flush_addr = tgt;
        flush_half = fh;
        illegal    = ill;
        #1;
        valid = (m_state == 2);
        sz    = m_half ? 32'd2 : 32'd4;
        ea    = m_pc - 2 * sz;
        ftag  = (m_last == 1) ? "R6" : (m_last == 2) ? "R7" :
                (m_state < 2) ? "R2" : "R12";
        chk(fetch_addr, m_pc, ftag);
        chk({31'd0, exec_valid}, {31'd0, valid}, (m_last == 2) ? "R7" : "R2");
        chk({31'd0, half_mode}, {31'd0, m_half}, "R10");
        chk(next_addr, m_pc - 32'(m_state) * sz, "R8");
        chk({31'd0, trap}, {31'd0, valid && ill}, "R9");
        chk({31'd0, retire}, {31'd0, m_ret}, "R11");
        if (valid) begin
            w = memf(ea);
            if (m_half) w = {16'h0000, w[15:0]};
            chk(exec_addr, ea, "R5");
            chk(exec_word, w, m_half ? "R3" : "R4");
        end
        @(posedge clk);
        m_ret = valid;
        if (valid && fl) begin
            m_pc    = tgt & ~32'd1;
            m_state = 0;
            m_half  = fh;
            m_last  = 1;
        end else begin
            m_pc    = m_pc + sz;
            m_last  = (fl && !valid) ? 2 : 0;
            if (m_state < 2) m_state = m_state + 1;
        end
        @(negedge clk);
    endtask

    initial begin
        logic [15:0] lfsr;
        logic [31:0] targets [4];
        targets[0] = 32'h0000_2000;
        targets[1] = 32'h0000_3003;
        targets[2] = 32'hFFFF_FFF8;
        targets[3] = 32'h0000_0006;
        rst_n = 1'b0;
        flush_req = 1'b0; flush_addr = '0; flush_half = 1'b0; illegal = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset values
        chk(fetch_addr, RST_PC, "R1");
        chk(next_addr, RST_PC, "R1");
        chk({31'd0, exec_valid}, 32'd0, "R1");
        chk({31'd0, retire}, 32'd0, "R1");
        chk({31'd0, half_mode}, 32'd0, "R1");
        illegal = 1'b1;
        #1 chk({31'd0, trap}, 32'd0, "R1");
        illegal = 1'b0;
        rst_n  = 1'b1;
        m_pc = RST_PC; m_state = 0; m_half = 1'b0; m_ret = 1'b0; m_last = 0;

        // directed sweep: every mode pair, target and flush position
        for (int m0 = 0; m0 < 2; m0++)
            for (int m1 = 0; m1 < 2; m1++)
                for (int ti = 0; ti < 4; ti++)
                    for (int fp = 0; fp < 4; fp++) begin
                        // get into mode m0 at a base address
                        while (m_state != 2) do_step(1'b1, 32'h40, 1'b1, 1'b1);
                        do_step(1'b1, 32'h0000_1000, m0[0], 1'b0);
                        for (int k = 0; k < fp + 2; k++)
                            do_step(k == 0, 32'h7777_0000, ~m1[0], k[0]);
                        do_step(1'b1, targets[ti], m1[0], 1'b1);
                        for (int k = 0; k < 5; k++)
                            do_step(1'b0, '0, 1'b0, k == 2);
                    end

        // pseudo-random stress
        lfsr = 16'hACE1;
        for (int i = 0; i < 3000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            do_step(lfsr[1:0] == 2'b00, {16'h0, lfsr} ^ 32'h0001_0000,
                    lfsr[5], lfsr[7]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule